// File: doc/BRIEF.md
# SPI Status, Error and Interrupt Unit

This block keeps the flag side of an SPI port: it counts words waiting in the transmit and receive queues, raises overrun and mode-fault errors, tracks whether a frame is in flight, manages the slave-select pin and folds every enabled condition into a single interrupt line. The serial shifter beside it reports `frame_start` when it takes a word and begins a frame, and `frame_done` when a received word is ready. Register accesses from the host arrive as one-cycle strobes: status read, data read, data write, and writes to two control registers.

The error flags cannot be cleared by writing ones to them. Overrun clears only after a data read followed by a status read. Mode fault clears only after a status read followed by a write to the first control register. A mode fault also drops both the enable and the master bit. Busy is held by a four-state machine. `BS_OFF` is the disabled state. `BS_IDLE` means enabled with no frame. `BS_SHIFT` means a frame is in flight, and `BS_GAP` is the slave's forced quiet period after a frame. Its transitions are:
- OFF→IDLE (enable).
- IDLE→SHIFT (accepted start).
- SHIFT→SHIFT (master done with data pending).
- SHIFT→IDLE (master done with nothing pending).
- SHIFT→GAP (slave done).
- GAP→IDLE (gap counter expired).
- any→OFF (the next enable value is 0).

Top module: `spi_status_unit`

## Requirements
- R1: After reset, enable, master, busy, overrun, mode fault and receive-not-empty are 0. Transmit-empty is 1, both level codes are 00, the interrupt is 0 and slave-select is not driven.
- R2: A `frame_done` while the receive queue is not full adds one word. A `dr_rd` with a word present removes one. `rxne_o` is 1 while any word is held. `rx_lvl_o` reads 00 when empty, 01 when partly filled and 11 when full.
- R3: A `frame_done` while the receive queue is full sets `ovr_o` on the next cycle and discards the new word, so the receive level does not change.
- R4: `ovr_o` clears only when a `sr_rd` comes after an earlier `dr_rd` that was seen while overrun was set. A status read on its own, or a status read before the data read, leaves it set.
- R5: If the block is enabled as master in slave-select mode 00 (hardware input) and `ss_in_n` is low, then on the next cycle `modf_o` is 1 and enable, master and busy are 0.
- R6: `modf_o` clears only on a `ctl1_wr` that follows a `sr_rd` seen while mode fault was set. A control write with no prior status read leaves it set.
- R7: `dr_wr` adds a word to the transmit queue, and a write when the queue is full is ignored. An accepted `frame_start` removes a word. `txe_o` is 1 when the queue is empty. `tx_lvl_o` uses the same 00/01/11 codes as the receive level.
- R8: A `ctl2_wr` with `ctl2_clr_tx` set empties the transmit queue on the next cycle, even if a data write arrives in the same cycle.
- R9: In master mode, `busy_o` rises one cycle after an accepted `frame_start`. It stays high across a `frame_done` while transmit data is pending, and falls after a `frame_done` with nothing pending.
- R10: In slave mode, `busy_o` falls after every `frame_done` and stays low for GAP_CYCLES cycles. A `frame_start` during that time is ignored: busy does not rise and the transmit level does not change.
- R11: A `ctl1_wr` with `ctl1_en` at 0 clears `en_o` and `busy_o` on the next cycle, including in the middle of a frame.
- R12: Slave-select mode 10 (hardware output) drives `ss_oe_o`=1 and `ss_out_n_o`=0 while the block is enabled as master. Modes 01 and 11 (software) never raise a mode fault. `eng_sel_o` is 1 when the block is enabled and is either master, in software mode, or sees `ss_in_n` low.
- R13: `irq_o` is the OR of three terms: receive-not-empty with its enable, transmit-empty with its enable, and (overrun or mode fault) with the shared error enable. The enables are loaded by `ctl2_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl1_wr | input | 1 | Write strobe for control register 1 |
| ctl1_en | input | 1 | Enable value written by `ctl1_wr` |
| ctl1_mstr | input | 1 | Master value written by `ctl1_wr` |
| ctl1_ss_mode | input | 2 | Slave-select mode: 00 hw input, 01/11 software, 10 hw output |
| ctl2_wr | input | 1 | Write strobe for control register 2 |
| ctl2_ie_rx | input | 1 | Receive-not-empty interrupt enable |
| ctl2_ie_tx | input | 1 | Transmit-empty interrupt enable |
| ctl2_ie_err | input | 1 | Error interrupt enable (overrun, mode fault) |
| ctl2_clr_tx | input | 1 | Command: discard pending transmit words |
| sr_rd | input | 1 | Status register read strobe |
| dr_rd | input | 1 | Data register read strobe |
| dr_wr | input | 1 | Data register write strobe |
| frame_start | input | 1 | Engine takes a word and begins a frame |
| frame_done | input | 1 | Engine finished a frame with a received word |
| ss_in_n | input | 1 | Slave-select pin level |
| en_o | output | 1 | Peripheral enabled |
| mstr_o | output | 1 | Master mode |
| rxne_o | output | 1 | Receive queue not empty |
| txe_o | output | 1 | Transmit queue empty |
| busy_o | output | 1 | Frame in flight |
| modf_o | output | 1 | Mode fault flag |
| ovr_o | output | 1 | Overrun flag |
| tx_lvl_o | output | 2 | Transmit level code |
| rx_lvl_o | output | 2 | Receive level code |
| irq_o | output | 1 | Combined interrupt |
| ss_oe_o | output | 1 | Slave-select output enable |
| ss_out_n_o | output | 1 | Slave-select output level |
| eng_sel_o | output | 1 | Engine is selected and may shift |

## Verification
A wrong arm bit in either clear sequence shows up as an error flag that falls one cycle early or never falls. This is visible at `ovr_o` or `modf_o` on the cycle after the status read or control write that completes the sequence. A busy state machine in the wrong state shows up within one cycle at `busy_o`. It can also surface later as a transmit level that moves on a start that should have been ignored. A queue count off by one shows up on the first level code that crosses the empty or full edge, and spreads to `irq_o` the same cycle.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    typedef enum logic [1:0] {
        BS_OFF   = 2'd0,
        BS_IDLE  = 2'd1,
        BS_SHIFT = 2'd2,
        BS_GAP   = 2'd3
    } busy_st_e;

    localparam logic [1:0] SSM_HW_IN  = 2'b00;
    localparam logic [1:0] SSM_SOFT   = 2'b01;
    localparam logic [1:0] SSM_HW_OUT = 2'b10;

    localparam logic [1:0] LVL_EMPTY = 2'b00;
    localparam logic [1:0] LVL_PART  = 2'b01;
    localparam logic [1:0] LVL_FULL  = 2'b11;

    function automatic logic [1:0] lvl_code(input logic empty, input logic full);
        if (empty)     return LVL_EMPTY;
        else if (full) return LVL_FULL;
        else           return LVL_PART;
    endfunction

    function automatic logic is_soft(input logic [1:0] mode);
        return mode[0];
    endfunction

endpackage

// File: rtl/spi_occ_counter.sv
module spi_occ_counter #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  logic flush,
    output logic empty,
    output logic full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] TOP = CW'(DEPTH);

    logic [CW-1:0] cnt_q;
    logic do_push, do_pop;

    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (flush)
            cnt_q <= '0;
        else if (do_push && !do_pop)
            cnt_q <= cnt_q + CW'(1);
        else if (do_pop && !do_push)
            cnt_q <= cnt_q - CW'(1);
    end

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == TOP);
endmodule

// File: rtl/spi_mode_err.sv
module spi_mode_err
    import spi_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl1_wr,
    input  logic       ctl1_en,
    input  logic       ctl1_mstr,
    input  logic [1:0] ctl1_ss_mode,
    input  logic       sr_rd,
    input  logic       dr_rd,
    input  logic       ss_in_n,
    input  logic       ovr_evt,
    output logic       en_q,
    output logic       en_nxt,
    output logic       mstr_q,
    output logic [1:0] ss_mode_q,
    output logic       modf_q,
    output logic       ovr_q
);
    logic fault;
    logic mstr_nxt, modf_nxt, ovr_nxt;
    logic modf_arm_q, modf_arm_nxt;
    logic ovr_arm_q, ovr_arm_nxt;
    logic [1:0] mode_nxt;

    // master driven low on a hardware-input select pin
    assign fault = en_q & mstr_q & (ss_mode_q == SSM_HW_IN) & ~ss_in_n;

    always_comb begin
        en_nxt   = en_q;
        mstr_nxt = mstr_q;
        mode_nxt = ss_mode_q;
        if (ctl1_wr) begin
            en_nxt   = ctl1_en;
            mstr_nxt = ctl1_mstr;
            mode_nxt = ctl1_ss_mode;
        end
        if (fault) begin
            en_nxt   = 1'b0;
            mstr_nxt = 1'b0;
        end
    end

    // mode fault: status read arms, control-1 write clears
    always_comb begin
        modf_nxt     = modf_q;
        modf_arm_nxt = modf_arm_q;
        if (fault) begin
            modf_nxt     = 1'b1;
            modf_arm_nxt = 1'b0;
        end else if (ctl1_wr) begin
            if (modf_arm_q) modf_nxt = 1'b0;
            modf_arm_nxt = 1'b0;
        end else if (sr_rd && modf_q) begin
            modf_arm_nxt = 1'b1;
        end
    end

    // overrun: data read arms, status read clears
    always_comb begin
        ovr_nxt     = ovr_q;
        ovr_arm_nxt = ovr_arm_q;
        if (ovr_evt) begin
            ovr_nxt     = 1'b1;
            ovr_arm_nxt = 1'b0;
        end else if (sr_rd && ovr_arm_q) begin
            ovr_nxt     = 1'b0;
            ovr_arm_nxt = 1'b0;
        end else if (dr_rd && ovr_q) begin
            ovr_arm_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            mstr_q     <= 1'b0;
            ss_mode_q  <= SSM_SOFT;
            modf_q     <= 1'b0;
            modf_arm_q <= 1'b0;
            ovr_q      <= 1'b0;
            ovr_arm_q  <= 1'b0;
        end else begin
            en_q       <= en_nxt;
            mstr_q     <= mstr_nxt;
            ss_mode_q  <= mode_nxt;
            modf_q     <= modf_nxt;
            modf_arm_q <= modf_arm_nxt;
            ovr_q      <= ovr_nxt;
            ovr_arm_q  <= ovr_arm_nxt;
        end
    end
endmodule

// File: rtl/spi_busy_fsm.sv
module spi_busy_fsm
    import spi_stat_pkg::*;
#(
    parameter int GAP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_nxt,
    input  logic mstr,
    input  logic frame_start,
    input  logic frame_done,
    input  logic tx_pending,
    output logic busy,
    output logic start_ok
);
    localparam int GW = $clog2(GAP_CYCLES + 1);
    localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYCLES - 1);

    busy_st_e state_q, state_d;
    logic [GW-1:0] gap_q;

    // state register and gap counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BS_OFF;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == BS_SHIFT && state_d == BS_GAP)
                gap_q <= GAP_LOAD;
            else if (state_q == BS_GAP && gap_q != '0)
                gap_q <= gap_q - GW'(1);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!en_nxt) begin
            state_d = BS_OFF;
        end else begin
            unique case (state_q)
                BS_OFF:   state_d = BS_IDLE;
                BS_IDLE:  if (start_ok) state_d = BS_SHIFT;
                BS_SHIFT: begin
                    if (frame_done) begin
                        if (!mstr)          state_d = BS_GAP;
                        else if (tx_pending) state_d = BS_SHIFT;
                        else                state_d = BS_IDLE;
                    end
                end
                BS_GAP:   if (gap_q == '0) state_d = BS_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q == BS_SHIFT);
        start_ok = frame_start & en_nxt &
                   ((state_q == BS_IDLE) || (state_q == BS_SHIFT));
    end
endmodule

// File: rtl/spi_status_unit.sv
module spi_status_unit
    import spi_stat_pkg::*;
#(
    parameter int TX_DEPTH   = 2,
    parameter int RX_DEPTH   = 1,
    parameter int GAP_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl1_wr,
    input  logic       ctl1_en,
    input  logic       ctl1_mstr,
    input  logic [1:0] ctl1_ss_mode,
    input  logic       ctl2_wr,
    input  logic       ctl2_ie_rx,
    input  logic       ctl2_ie_tx,
    input  logic       ctl2_ie_err,
    input  logic       ctl2_clr_tx,
    input  logic       sr_rd,
    input  logic       dr_rd,
    input  logic       dr_wr,
    input  logic       frame_start,
    input  logic       frame_done,
    input  logic       ss_in_n,
    output logic       en_o,
    output logic       mstr_o,
    output logic       rxne_o,
    output logic       txe_o,
    output logic       busy_o,
    output logic       modf_o,
    output logic       ovr_o,
    output logic [1:0] tx_lvl_o,
    output logic [1:0] rx_lvl_o,
    output logic       irq_o,
    output logic       ss_oe_o,
    output logic       ss_out_n_o,
    output logic       eng_sel_o
);
    logic en_nxt, start_ok;
    logic [1:0] ss_mode_q;
    logic tx_empty, tx_full, rx_empty, rx_full;
    logic ovr_evt, tx_flush;
    logic ie_rx_q, ie_tx_q, ie_err_q;

    assign ovr_evt  = frame_done & rx_full;
    assign tx_flush = ctl2_wr & ctl2_clr_tx;

    spi_mode_err u_mode (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl1_wr      (ctl1_wr),
        .ctl1_en      (ctl1_en),
        .ctl1_mstr    (ctl1_mstr),
        .ctl1_ss_mode (ctl1_ss_mode),
        .sr_rd        (sr_rd),
        .dr_rd        (dr_rd),
        .ss_in_n      (ss_in_n),
        .ovr_evt      (ovr_evt),
        .en_q         (en_o),
        .en_nxt       (en_nxt),
        .mstr_q       (mstr_o),
        .ss_mode_q    (ss_mode_q),
        .modf_q       (modf_o),
        .ovr_q        (ovr_o)
    );

    spi_busy_fsm #(.GAP_CYCLES(GAP_CYCLES)) u_busy (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_nxt      (en_nxt),
        .mstr        (mstr_o),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .tx_pending  (~tx_empty),
        .busy        (busy_o),
        .start_ok    (start_ok)
    );

    spi_occ_counter #(.DEPTH(TX_DEPTH)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (dr_wr),
        .pop   (start_ok),
        .flush (tx_flush),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spi_occ_counter #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (frame_done),
        .pop   (dr_rd),
        .flush (1'b0),
        .empty (rx_empty),
        .full  (rx_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_rx_q  <= 1'b0;
            ie_tx_q  <= 1'b0;
            ie_err_q <= 1'b0;
        end else if (ctl2_wr) begin
            ie_rx_q  <= ctl2_ie_rx;
            ie_tx_q  <= ctl2_ie_tx;
            ie_err_q <= ctl2_ie_err;
        end
    end

    always_comb begin
        rxne_o     = ~rx_empty;
        txe_o      = tx_empty;
        tx_lvl_o   = lvl_code(tx_empty, tx_full);
        rx_lvl_o   = lvl_code(rx_empty, rx_full);
        irq_o      = (rxne_o & ie_rx_q) | (txe_o & ie_tx_q) |
                     ((ovr_o | modf_o) & ie_err_q);
        ss_oe_o    = en_o & mstr_o & (ss_mode_q == SSM_HW_OUT);
        ss_out_n_o = ~ss_oe_o;
        eng_sel_o  = en_o & (mstr_o | is_soft(ss_mode_q) | ~ss_in_n);
    end
endmodule

// File: rtl/spi_status_unit_chk.sv
module spi_status_unit_chk
    import spi_stat_pkg::*;
#(
    parameter int GAP_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl1_wr,
    input logic       ctl2_wr,
    input logic       ctl2_clr_tx,
    input logic       sr_rd,
    input logic       dr_rd,
    input logic       dr_wr,
    input logic       frame_start,
    input logic       frame_done,
    input logic       ss_in_n,
    input logic       en_o,
    input logic       mstr_o,
    input logic       txe_o,
    input logic       busy_o,
    input logic       modf_o,
    input logic       ovr_o,
    input logic [1:0] tx_lvl_o,
    input logic [1:0] rx_lvl_o,
    input logic [1:0] ss_mode_q
);
    assert_modf_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && mstr_o && ss_mode_q == SSM_HW_IN && !ss_in_n)
        |=> (modf_o && !en_o && !mstr_o && !busy_o));

    assert_ovr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_lvl_o == LVL_FULL) |=> ovr_o);

    assert_rx_discard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && rx_lvl_o == LVL_FULL && !dr_rd) |=> (rx_lvl_o == LVL_FULL));

    assert_ovr_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_o) |-> $past(sr_rd));

    assert_modf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(modf_o) |-> $past(ctl1_wr));

    assert_busy_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |-> !busy_o);

    assert_txclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl2_wr && ctl2_clr_tx) |=> txe_o);

    assert_txpush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_wr && tx_lvl_o == LVL_EMPTY && !(ctl2_wr && ctl2_clr_tx) && !frame_start)
        |=> !txe_o);

    if (GAP_CYCLES >= 2) begin : g_gap
        assert_slave_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(busy_o) && en_o && !$past(mstr_o)) |=> !busy_o);
    end
endmodule

bind spi_status_unit spi_status_unit_chk #(.GAP_CYCLES(GAP_CYCLES)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl1_wr     (ctl1_wr),
    .ctl2_wr     (ctl2_wr),
    .ctl2_clr_tx (ctl2_clr_tx),
    .sr_rd       (sr_rd),
    .dr_rd       (dr_rd),
    .dr_wr       (dr_wr),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .ss_in_n     (ss_in_n),
    .en_o        (en_o),
    .mstr_o      (mstr_o),
    .txe_o       (txe_o),
    .busy_o      (busy_o),
    .modf_o      (modf_o),
    .ovr_o       (ovr_o),
    .tx_lvl_o    (tx_lvl_o),
    .rx_lvl_o    (rx_lvl_o),
    .ss_mode_q   (ss_mode_q)
);

// File: tb/spi_status_unit_tb_top.sv
module spi_status_unit_tb_top;
    localparam int TXD  = 2;
    localparam int RXD  = 1;
    localparam int GAPC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl1_wr = 0, ctl1_en = 0, ctl1_mstr = 0;
    logic [1:0] ctl1_ss_mode = 2'b01;
    logic ctl2_wr = 0, ctl2_ie_rx = 0, ctl2_ie_tx = 0, ctl2_ie_err = 0, ctl2_clr_tx = 0;
    logic sr_rd = 0, dr_rd = 0, dr_wr = 0, frame_start = 0, frame_done = 0;
    logic ss_in_n = 1'b1;
    logic en_o, mstr_o, rxne_o, txe_o, busy_o, modf_o, ovr_o, irq_o;
    logic ss_oe_o, ss_out_n_o, eng_sel_o;
    logic [1:0] tx_lvl_o, rx_lvl_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    bit m_en, m_mstr, m_ierx, m_ietx, m_ieerr, m_modf, m_marm, m_ovr, m_oarm;
    int m_mode, m_tx, m_rx, m_st, m_gap;

    always #2.5 clk = ~clk;

    spi_status_unit #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .GAP_CYCLES(GAPC)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl1_wr(ctl1_wr), .ctl1_en(ctl1_en), .ctl1_mstr(ctl1_mstr), .ctl1_ss_mode(ctl1_ss_mode),
        .ctl2_wr(ctl2_wr), .ctl2_ie_rx(ctl2_ie_rx), .ctl2_ie_tx(ctl2_ie_tx),
        .ctl2_ie_err(ctl2_ie_err), .ctl2_clr_tx(ctl2_clr_tx),
        .sr_rd(sr_rd), .dr_rd(dr_rd), .dr_wr(dr_wr),
        .frame_start(frame_start), .frame_done(frame_done), .ss_in_n(ss_in_n),
        .en_o(en_o), .mstr_o(mstr_o), .rxne_o(rxne_o), .txe_o(txe_o), .busy_o(busy_o),
        .modf_o(modf_o), .ovr_o(ovr_o), .tx_lvl_o(tx_lvl_o), .rx_lvl_o(rx_lvl_o),
        .irq_o(irq_o), .ss_oe_o(ss_oe_o), .ss_out_n_o(ss_out_n_o), .eng_sel_o(eng_sel_o)
    );

    function automatic int lvl(int cnt, int depth);
        if (cnt == 0) return 0;
        if (cnt == depth) return 3;
        return 1;
    endfunction

    function automatic bit exp_irq();
        return ((m_rx != 0) && m_ierx) || ((m_tx == 0) && m_ietx) ||
               ((m_ovr || m_modf) && m_ieerr);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_en = 0; m_mstr = 0; m_mode = 1; m_ierx = 0; m_ietx = 0; m_ieerr = 0;
        m_modf = 0; m_marm = 0; m_ovr = 0; m_oarm = 0; m_tx = 0; m_rx = 0; m_st = 0; m_gap = 0;
    endtask

    task automatic model_step();
        bit fault, en_n, mstr_n, rxfull, oevt, sok, pend;
        int mode_n, st_n;
        fault  = m_en && m_mstr && (m_mode == 0) && !ss_in_n;
        en_n   = ctl1_wr ? ctl1_en : m_en;
        mstr_n = ctl1_wr ? ctl1_mstr : m_mstr;
        mode_n = ctl1_wr ? int'(ctl1_ss_mode) : m_mode;
        if (fault) begin en_n = 0; mstr_n = 0; end
        if (fault) begin m_modf = 1; m_marm = 0; end
        else if (ctl1_wr) begin if (m_marm) m_modf = 0; m_marm = 0; end
        else if (sr_rd && m_modf) m_marm = 1;
        rxfull = (m_rx == RXD);
        oevt   = frame_done && rxfull;
        if (oevt) begin m_ovr = 1; m_oarm = 0; end
        else if (sr_rd && m_oarm) begin m_ovr = 0; m_oarm = 0; end
        else if (dr_rd && m_ovr) m_oarm = 1;
        sok  = frame_start && en_n && (m_st == 1 || m_st == 2);
        pend = (m_tx != 0);
        st_n = m_st;
        if (!en_n) st_n = 0;
        else case (m_st)
            0: st_n = 1;
            1: if (sok) st_n = 2;
            2: if (frame_done) st_n = !m_mstr ? 3 : (pend ? 2 : 1);
            default: if (m_gap == 0) st_n = 1;
        endcase
        if (m_st == 2 && st_n == 3) m_gap = GAPC - 1;
        else if (m_st == 3 && m_gap != 0) m_gap--;
        m_st = st_n;
        if (frame_done && !rxfull && !(dr_rd && m_rx != 0)) m_rx++;
        else if (!(frame_done && !rxfull) && dr_rd && m_rx != 0) m_rx--;
        if (ctl2_wr && ctl2_clr_tx) m_tx = 0;
        else begin
            bit pu, po;
            pu = dr_wr && (m_tx < TXD);
            po = sok && (m_tx != 0);
            if (pu && !po) m_tx++;
            else if (po && !pu) m_tx--;
        end
        if (ctl2_wr) begin m_ierx = ctl2_ie_rx; m_ietx = ctl2_ie_tx; m_ieerr = ctl2_ie_err; end
        m_en = en_n; m_mstr = mstr_n; m_mode = mode_n;
    endtask

    task automatic compare_all();
        bit soe;
        soe = m_en && m_mstr && (m_mode == 2);
        chk("R5 en", en_o, m_en);
        chk("R5 mstr", mstr_o, m_mstr);
        chk("R5 modf", modf_o, m_modf);
        chk("R3 ovr", ovr_o, m_ovr);
        chk("R2 rxne", rxne_o, m_rx != 0);
        chk("R2 rx_lvl", rx_lvl_o, lvl(m_rx, RXD));
        chk("R7 txe", txe_o, m_tx == 0);
        chk("R7 tx_lvl", tx_lvl_o, lvl(m_tx, TXD));
        chk("R9 busy", busy_o, m_st == 2);
        chk("R13 irq", irq_o, exp_irq());
        chk("R12 ss_oe", ss_oe_o, soe);
        chk("R12 ss_out_n", ss_out_n_o, !soe);
        chk("R12 eng_sel", eng_sel_o, m_en && (m_mstr || (m_mode % 2 == 1) || !ss_in_n));
    endtask

    task automatic clear_strobes();
        ctl1_wr = 0; ctl2_wr = 0; ctl2_clr_tx = 0;
        sr_rd = 0; dr_rd = 0; dr_wr = 0; frame_start = 0; frame_done = 0;
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        #1;
        compare_all();
        clear_strobes();
    endtask

    task automatic wr1(bit en, bit ms, logic [1:0] mode);
        ctl1_wr = 1; ctl1_en = en; ctl1_mstr = ms; ctl1_ss_mode = mode; cycle();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 txe", txe_o, 1);
        chk("R1 ovr|modf", ovr_o | modf_o, 0);
        chk("R1 irq", irq_o, 0);
        chk("R1 ss_out_n", ss_out_n_o, 1);
        compare_all();

        // R12 master with hardware-output select
        wr1(1, 1, 2'b10);
        chk("R12 ss_oe", ss_oe_o, 1);
        // R13 transmit-empty interrupt
        ctl2_wr = 1; ctl2_ie_tx = 1; ctl2_ie_rx = 1; ctl2_ie_err = 1; cycle();
        chk("R13 irq txe", irq_o, 1);
        // R7 fill, overfill ignored
        dr_wr = 1; cycle();
        dr_wr = 1; cycle();
        dr_wr = 1; cycle();
        chk("R7 full", tx_lvl_o, 3);
        // R9 master busy through back-to-back frames
        frame_start = 1; cycle();
        chk("R9 busy rise", busy_o, 1);
        frame_done = 1; cycle();
        chk("R9 busy held pending", busy_o, 1);
        frame_start = 1; cycle();
        dr_wr = 1; cycle();
        frame_start = 1; cycle();
        frame_done = 1; cycle();
        chk("R9 busy drop", busy_o, 0);
        chk("R3 ovr on full rx", ovr_o, 1);
        chk("R3 rx kept full", rx_lvl_o, 3);
        // R4 order: status read first does not clear
        sr_rd = 1; cycle();
        dr_rd = 1; cycle();
        chk("R4 ovr still set", ovr_o, 1);
        chk("R2 rx emptied", rxne_o, 0);
        sr_rd = 1; cycle();
        chk("R4 ovr cleared", ovr_o, 0);
        // R8 clear transmit queue, same-cycle write loses
        dr_wr = 1; cycle();
        dr_wr = 1; ctl2_wr = 1; ctl2_clr_tx = 1; ctl2_ie_tx = 0; cycle();
        chk("R8 txe after clear", txe_o, 1);
        // R10 slave gap
        wr1(1, 0, 2'b01);
        dr_wr = 1; cycle();
        frame_start = 1; cycle();
        frame_done = 1; cycle();
        chk("R10 busy low after frame", busy_o, 0);
        dr_rd = 1; dr_wr = 1; cycle();
        for (int i = 0; i < GAPC - 1; i++) begin
            frame_start = 1; cycle();
            chk("R10 start ignored in gap", busy_o, 0);
        end
        chk("R10 tx level kept", tx_lvl_o, 1);
        frame_start = 1; cycle();
        chk("R10 start after gap", busy_o, 1);
        // R11 disable mid-frame
        wr1(0, 0, 2'b01);
        chk("R11 busy off", busy_o, 0);
        chk("R11 en off", en_o, 0);
        // R5 mode fault
        wr1(1, 1, 2'b00);
        ss_in_n = 0; cycle();
        chk("R5 modf", modf_o, 1);
        chk("R5 en cleared", en_o, 0);
        chk("R13 irq err", irq_o, 1);
        ss_in_n = 1;
        // R6 write without status read keeps flag
        wr1(0, 0, 2'b01);
        chk("R6 modf kept", modf_o, 1);
        sr_rd = 1; cycle();
        wr1(0, 0, 2'b01);
        chk("R6 modf cleared", modf_o, 0);
        // R12 software mode never faults
        wr1(1, 1, 2'b01);
        ss_in_n = 0; cycle(); cycle();
        chk("R12 no fault soft", modf_o, 0);
        ss_in_n = 1;

        // constrained random phase
        for (int k = 0; k < 4000; k++) begin
            ctl1_wr      = ($urandom % 40) == 0;
            ctl1_en      = ($urandom % 4) != 0;
            ctl1_mstr    = ($urandom % 2) == 1;
            ctl1_ss_mode = 2'($urandom % 4);
            ctl2_wr      = ($urandom % 30) == 0;
            ctl2_ie_rx   = ($urandom % 2) == 1;
            ctl2_ie_tx   = ($urandom % 2) == 1;
            ctl2_ie_err  = ($urandom % 2) == 1;
            ctl2_clr_tx  = ($urandom % 3) == 0;
            sr_rd        = ($urandom % 5) == 0;
            dr_rd        = ($urandom % 4) == 0;
            dr_wr        = ($urandom % 3) == 0;
            frame_start  = ($urandom % 4) == 0;
            frame_done   = (m_st == 2) && !frame_start && (($urandom % 3) == 0);
            ss_in_n      = ($urandom % 10) != 0;
            cycle();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule